// File: doc/BRIEF.md
# Push-Button HH:MM Alarm Clock Core

This block is the timekeeping and setting logic of a four-digit, 24-hour alarm clock. The running time is kept as four BCD digits (hours tens, hours units, minutes tens, minutes units). It advances by one minute on each pulse of a minute-tick input. The user works with four push buttons. A field button picks whether hours or minutes are edited. An increment button bumps the selected field of a shared entry buffer. A set-time button copies the buffer into the running clock. A set-alarm button copies the buffer into the stored alarm, or, when nothing is being edited, toggles a view of the stored alarm.

The block picks which four digits go to the display by priority. It flags when the alarm equals the running time and gates a tone square wave onto a speaker output during that match. It also drives a seconds indicator with a one-second period. Button debouncing, segment decoding and digit multiplexing belong to neighbouring blocks. The button inputs are expected clean and synchronous.

Top module: `alarm_clock_core`

## Requirements
- R1: After reset, `disp_digits` reads 16'h0000 and `sec_led` is low. The display packs hours tens in [15:12], hours units in [11:8], minutes tens in [7:4] and minutes units in [3:0], each digit in BCD.
- R2: A field press toggles the edited field. Hours are selected after reset or clear. A field press or an increment press starts editing.
- R3: An increment press adds one to the selected field of the entry buffer and leaves the other field unchanged. Hours wrap from 23 to 00, and minutes wrap from 59 to 00 with no carry into the hours.
- R4: A set-time press while editing loads the entry buffer into the running time and ends editing. When not editing, the press has no effect.
- R5: A set-alarm press while editing loads the entry buffer into the alarm, ends editing and turns the alarm view off. When not editing, the press toggles the alarm view.
- R6: The display shows the entry buffer while editing. Otherwise it shows the alarm while the alarm view is on. Otherwise it shows the running time.
- R7: Each minute tick advances the running time by one minute, and 23:59 becomes 00:00. A set-time commit in the same cycle as a tick takes precedence. Editing does not stop the clock.
- R8: `alarm_match` is high exactly when all four alarm digits equal the running-time digits. `speaker` is `alarm_match` ANDed with a square wave of half period TONE_HALF clock cycles, and is low whenever there is no match.
- R9: `sec_led` is a square wave with a 50% duty cycle and a period of CLK_HZ clock cycles.
- R10: Each button acts on its rising edge only. A button held for several cycles produces exactly one action.
- R11: Only one button action takes effect per cycle. When presses coincide, the priority is set-time, then set-alarm, then field, then increment.
- R12: `clr` high at a clock edge zeroes the running time, the alarm and the entry buffer, ends editing, turns the alarm view off and selects hours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous active-high clear |
| min_tick | input | 1 | One-cycle pulse once per minute |
| btn_field | input | 1 | Hours/minutes field select button level |
| btn_inc | input | 1 | Increment button level |
| btn_time | input | 1 | Set-time button level |
| btn_alarm | input | 1 | Set-alarm / show-alarm button level |
| disp_digits | output | 16 | Four BCD digits selected for display |
| alarm_match | output | 1 | Alarm equals running time |
| speaker | output | 1 | Tone gated by the match |
| sec_led | output | 1 | Seconds indicator square wave |

## Verification
The bench builds the core with CLK_HZ set to 8 and TONE_HALF set to 1. With these values the seconds indicator completes a period every 8 cycles and the tone toggles every cycle, so the full duty cycle of both can be measured inside a 16-cycle window. Long stretches of repeated increments then walk the entry buffer through the 23-to-00 and 59-to-00 wraps. A committed 23:59 followed by a single tick exercises the midnight rollover without waiting for real minutes.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int DIGIT_W  = 4;
  localparam int NDIGITS  = 4;
  localparam int TIME_W   = DIGIT_W * NDIGITS;
  localparam int NBUTTONS = 4;

  localparam logic [DIGIT_W-1:0] HR_T_LAST = 4'd2;
  localparam logic [DIGIT_W-1:0] HR_U_LAST = 4'd3;
  localparam logic [DIGIT_W-1:0] MN_T_LAST = 4'd5;
  localparam logic [DIGIT_W-1:0] U_LAST    = 4'd9;

  // Button index into the pressed-pulse vector
  localparam int BI_FIELD = 0;
  localparam int BI_INC   = 1;
  localparam int BI_TIME  = 2;
  localparam int BI_ALARM = 3;

  typedef struct packed {
    logic [DIGIT_W-1:0] hr_t;
    logic [DIGIT_W-1:0] hr_u;
    logic [DIGIT_W-1:0] mn_t;
    logic [DIGIT_W-1:0] mn_u;
  } hhmm_t;

  localparam hhmm_t HHMM_ZERO = '0;

  function automatic hhmm_t bump_hour(hhmm_t t);
    hhmm_t r;
    r = t;
    if (t.hr_t == HR_T_LAST && t.hr_u == HR_U_LAST) begin
      r.hr_t = '0;
      r.hr_u = '0;
    end else if (t.hr_u == U_LAST) begin
      r.hr_t = t.hr_t + 4'd1;
      r.hr_u = '0;
    end else begin
      r.hr_u = t.hr_u + 4'd1;
    end
    return r;
  endfunction

  function automatic hhmm_t bump_min(hhmm_t t);
    hhmm_t r;
    r = t;
    if (t.mn_u == U_LAST) begin
      r.mn_u = '0;
      if (t.mn_t == MN_T_LAST) r.mn_t = '0;
      else                     r.mn_t = t.mn_t + 4'd1;
    end else begin
      r.mn_u = t.mn_u + 4'd1;
    end
    return r;
  endfunction

  function automatic logic min_at_end(hhmm_t t);
    return (t.mn_t == MN_T_LAST) && (t.mn_u == U_LAST);
  endfunction

  function automatic hhmm_t tick_once(hhmm_t t);
    hhmm_t r;
    r = bump_min(t);
    if (min_at_end(t)) r = bump_hour(r);
    return r;
  endfunction

endpackage

// File: rtl/acc_edge_detect.sv
module acc_edge_detect #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] pulse
);

  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    prev_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign pulse = lvl & ~prev_q;

endmodule

// File: rtl/acc_divider.sv
module acc_divider #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic wave
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wave_q, wave_d;

  always_comb begin
    cnt_d  = cnt_q;
    wave_d = wave_q;
    if (cnt_q == LAST) begin
      cnt_d  = '0;
      wave_d = ~wave_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wave_q <= wave_d;
    end
  end

  assign wave = wave_q;

endmodule

// File: rtl/acc_time_keeper.sv
module acc_time_keeper
  import acc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  load,
  input  hhmm_t load_val,
  input  logic  tick,
  output hhmm_t run
);

  hhmm_t run_q, run_d;
  logic  run_en;

  always_comb begin
    run_d  = run_q;
    run_en = 1'b0;
    if (clr) begin
      run_d  = HHMM_ZERO;
      run_en = 1'b1;
    end else if (load) begin
      run_d  = load_val;
      run_en = 1'b1;
    end else if (tick) begin
      run_d  = tick_once(run_q);
      run_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= HHMM_ZERO;
    else if (run_en) run_q <= run_d;
  end

  assign run = run_q;

endmodule

// File: rtl/acc_entry_ctrl.sv
module acc_entry_ctrl
  import acc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  field_p,
  input  logic  inc_p,
  input  logic  time_p,
  input  logic  alarm_p,
  output hhmm_t entry,
  output hhmm_t alarm,
  output logic  editing,
  output logic  show_alarm,
  output logic  load_time
);

  hhmm_t ent_q, ent_d;
  hhmm_t alm_q, alm_d;
  logic  edit_q, edit_d;
  logic  show_q, show_d;
  logic  fld_q, fld_d;     // 0: hours, 1: minutes
  logic  ent_en, alm_en;

  always_comb begin
    ent_d     = ent_q;
    alm_d     = alm_q;
    edit_d    = edit_q;
    show_d    = show_q;
    fld_d     = fld_q;
    ent_en    = 1'b0;
    alm_en    = 1'b0;
    load_time = 1'b0;
    if (clr) begin
      ent_d  = HHMM_ZERO;
      alm_d  = HHMM_ZERO;
      ent_en = 1'b1;
      alm_en = 1'b1;
      edit_d = 1'b0;
      show_d = 1'b0;
      fld_d  = 1'b0;
    end else if (time_p) begin
      if (edit_q) begin
        load_time = 1'b1;
        edit_d    = 1'b0;
      end
    end else if (alarm_p) begin
      if (edit_q) begin
        alm_d  = ent_q;
        alm_en = 1'b1;
        edit_d = 1'b0;
        show_d = 1'b0;
      end else begin
        show_d = ~show_q;
      end
    end else if (field_p) begin
      fld_d  = ~fld_q;
      edit_d = 1'b1;
    end else if (inc_p) begin
      edit_d = 1'b1;
      ent_en = 1'b1;
      if (fld_q) ent_d = bump_min(ent_q);
      else       ent_d = bump_hour(ent_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edit_q <= 1'b0;
      show_q <= 1'b0;
      fld_q  <= 1'b0;
    end else begin
      edit_q <= edit_d;
      show_q <= show_d;
      fld_q  <= fld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_q <= HHMM_ZERO;
    else if (ent_en) ent_q <= ent_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      alm_q <= HHMM_ZERO;
    else if (alm_en) alm_q <= alm_d;
  end

  assign entry      = ent_q;
  assign alarm      = alm_q;
  assign editing    = edit_q;
  assign show_alarm = show_q;

endmodule

// File: rtl/alarm_clock_core.sv
module alarm_clock_core
  import acc_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int TONE_HALF = 25_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              min_tick,
  input  logic              btn_field,
  input  logic              btn_inc,
  input  logic              btn_time,
  input  logic              btn_alarm,
  output logic [TIME_W-1:0] disp_digits,
  output logic              alarm_match,
  output logic              speaker,
  output logic              sec_led
);

  localparam int SEC_HALF = (CLK_HZ / 2 > 0) ? CLK_HZ / 2 : 1;

  logic [NBUTTONS-1:0] btn_lvl;
  logic [NBUTTONS-1:0] press_p;
  hhmm_t               run_q, ent_q, alm_q, shown;
  logic                edit_q, show_q, load_time;
  logic                tone;
  logic [NDIGITS-1:0]  digit_eq;

  always_comb begin
    btn_lvl           = '0;
    btn_lvl[BI_FIELD] = btn_field;
    btn_lvl[BI_INC]   = btn_inc;
    btn_lvl[BI_TIME]  = btn_time;
    btn_lvl[BI_ALARM] = btn_alarm;
  end

  acc_edge_detect #(.W(NBUTTONS)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (btn_lvl),
    .pulse (press_p)
  );

  acc_entry_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .field_p    (press_p[BI_FIELD]),
    .inc_p      (press_p[BI_INC]),
    .time_p     (press_p[BI_TIME]),
    .alarm_p    (press_p[BI_ALARM]),
    .entry      (ent_q),
    .alarm      (alm_q),
    .editing    (edit_q),
    .show_alarm (show_q),
    .load_time  (load_time)
  );

  acc_time_keeper u_clock (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .load     (load_time),
    .load_val (ent_q),
    .tick     (min_tick),
    .run      (run_q)
  );

  acc_divider #(.HALF(SEC_HALF)) u_sec (
    .clk   (clk),
    .rst_n (rst_n),
    .wave  (sec_led)
  );

  acc_divider #(.HALF(TONE_HALF)) u_tone (
    .clk   (clk),
    .rst_n (rst_n),
    .wave  (tone)
  );

  // Per-digit comparison of alarm against running time
  for (genvar gi = 0; gi < NDIGITS; gi++) begin : g_cmp
    assign digit_eq[gi] =
      (alm_q[gi*DIGIT_W +: DIGIT_W] == run_q[gi*DIGIT_W +: DIGIT_W]);
  end

  always_comb begin
    if (edit_q)      shown = ent_q;
    else if (show_q) shown = alm_q;
    else             shown = run_q;
  end

  assign disp_digits = shown;
  assign alarm_match = &digit_eq;
  assign speaker     = alarm_match & tone;

endmodule

// File: rtl/alarm_clock_core_checker.sv
module alarm_clock_core_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        min_tick,
  input logic        time_p,
  input logic        alarm_p,
  input logic        inc_p,
  input logic        editing,
  input logic        show_alarm,
  input logic [15:0] run_time,
  input logic [15:0] alarm_time,
  input logic [15:0] entry,
  input logic [15:0] disp,
  input logic        match,
  input logic        speaker
);

  assert_entry_bcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (entry[15:12] <= 4'd2) && (entry[7:4] <= 4'd5) && (entry[3:0] <= 4'd9) &&
    (entry[11:8] <= ((entry[15:12] == 4'd2) ? 4'd3 : 4'd9)));

  assert_run_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!min_tick && !time_p && !clr) |=> run_time == $past(run_time));

  assert_alarm_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_p && !clr) |=> alarm_time == $past(alarm_time));

  assert_edit_shows_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    editing |-> disp == entry);

  assert_idle_shows_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!editing && !show_alarm) |-> disp == run_time);

  assert_speaker_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    speaker |-> match);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inc_p |=> !inc_p);

  assert_clear_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (run_time == 16'h0000) && (alarm_time == 16'h0000) &&
            (entry == 16'h0000) && !editing && !show_alarm);

endmodule

bind alarm_clock_core alarm_clock_core_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .min_tick   (min_tick),
  .time_p     (press_p[2]),
  .alarm_p    (press_p[3]),
  .inc_p      (press_p[1]),
  .editing    (edit_q),
  .show_alarm (show_q),
  .run_time   (run_q),
  .alarm_time (alm_q),
  .entry      (ent_q),
  .disp       (disp_digits),
  .match      (alarm_match),
  .speaker    (speaker)
);

// File: tb/alarm_clock_core_test.sv
module alarm_clock_core_test;

  localparam int PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 50_000;

  // Stimulus masks: bit0 field, bit1 inc, bit2 set-time, bit3 set-alarm, bit4 tick
  localparam logic [4:0] F = 5'd1, I = 5'd2, T = 5'd4, A = 5'd8, K = 5'd16, N = 5'd0;

  // {mask, expected match, expected display}
  localparam int NVEC = 15;
  localparam logic [21:0] VEC [NVEC] = '{
    {I, 1'b1, 16'h0100},  // R3 hours +1, R2 edit starts
    {I, 1'b1, 16'h0200},  // R3
    {F, 1'b1, 16'h0200},  // R2 switch to minutes
    {I, 1'b1, 16'h0201},  // R3 minutes +1
    {T, 1'b0, 16'h0201},  // R4 commit time
    {I, 1'b0, 16'h0202},  // R2 edit again, minutes kept
    {A, 1'b0, 16'h0201},  // R5 commit alarm, back to time
    {A, 1'b0, 16'h0202},  // R5 idle alarm press shows alarm
    {K, 1'b1, 16'h0202},  // R7 tick, R8 match
    {A, 1'b1, 16'h0202},  // R5 view off, R6 time
    {K, 1'b0, 16'h0203},  // R7
    {F, 1'b0, 16'h0202},  // R2 back to hours, R6 buffer
    {I, 1'b0, 16'h0302},  // R3
    {T, 1'b0, 16'h0302},  // R4
    {N, 1'b0, 16'h0302}   // R6 quiet cycle
  };

  logic        clk = 1'b0;
  logic        rst_n, clr, min_tick, btn_field, btn_inc, btn_time, btn_alarm;
  logic [15:0] disp_digits;
  logic        alarm_match, speaker, sec_led;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  alarm_clock_core #(.CLK_HZ(8), .TONE_HALF(1)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .min_tick    (min_tick),
    .btn_field   (btn_field),
    .btn_inc     (btn_inc),
    .btn_time    (btn_time),
    .btn_alarm   (btn_alarm),
    .disp_digits (disp_digits),
    .alarm_match (alarm_match),
    .speaker     (speaker),
    .sec_led     (sec_led)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [4:0] m);
    btn_field = m[0];
    btn_inc   = m[1];
    btn_time  = m[2];
    btn_alarm = m[3];
    min_tick  = m[4];
  endtask

  // One press lasting one cycle; returns at a falling edge with results settled
  task automatic press(input logic [4:0] m);
    @(negedge clk);
    drive(m);
    @(negedge clk);
    drive(N);
  endtask

  task automatic press_n(input logic [4:0] m, input int n);
    for (int k = 0; k < n; k++) press(m);
  endtask

  task automatic speaker_ones(output int ones);
    ones = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (speaker) ones++;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    clr   = 1'b0;
    drive(N);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset display", disp_digits, 16'h0000);
    check("R1 reset sec_led", {15'd0, sec_led}, 16'd0);

    for (int v = 0; v < NVEC; v++) begin
      press(VEC[v][21:17]);
      check($sformatf("vector %0d display", v), disp_digits, VEC[v][15:0]);
      check($sformatf("vector %0d match R8", v), {15'd0, alarm_match}, {15'd0, VEC[v][16]});
    end

    // R10: held button gives one increment
    @(negedge clk); btn_inc = 1'b1;
    repeat (5) @(negedge clk);
    btn_inc = 1'b0;
    check("R10 held increment", disp_digits, 16'h0402);

    // R3 hour wrap
    press_n(I, 19);
    check("R3 hours reach 23", disp_digits, 16'h2302);
    press(I);
    check("R3 hours wrap", disp_digits, 16'h0002);
    press_n(I, 23);
    press(F);
    press_n(I, 57);
    check("R3 minutes reach 59", disp_digits, 16'h2359);
    press(I);
    check("R3 minutes wrap, hours kept", disp_digits, 16'h2300);
    press_n(I, 59);
    press(T);
    check("R4 commit 23:59", disp_digits, 16'h2359);
    press(K);
    check("R7 midnight rollover", disp_digits, 16'h0000);

    // R4 idle set-time ignored
    press(T);
    check("R4 idle set-time ignored", disp_digits, 16'h0000);
    press(A);
    check("R6 alarm view", disp_digits, 16'h0202);
    press(T);
    check("R4 set-time ignored in alarm view", disp_digits, 16'h0202);
    press(A);
    check("R5 alarm view off", disp_digits, 16'h0000);

    // R7 commit wins over a coincident tick
    press(F);
    check("R2 field to hours, edit", disp_digits, 16'h2359);
    press(I);
    check("R3 hour wrap keeps minutes", disp_digits, 16'h0059);
    press(T | K);
    check("R7 commit beats tick", disp_digits, 16'h0059);
    press(K);
    check("R7 tick after commit", disp_digits, 16'h0100);

    // R7 clock keeps running during edit
    press(F);
    check("R6 edit shows buffer", disp_digits, 16'h0059);
    press(K);
    check("R7 tick during edit leaves buffer", disp_digits, 16'h0059);
    press(A);
    check("R7 running time advanced during edit", disp_digits, 16'h0101);
    check("R8 no match", {15'd0, alarm_match}, 16'd0);
    press(A);
    check("R5 alarm view shows 00:59", disp_digits, 16'h0059);

    // R11 priority: set-time beats increment
    press(F);
    press(T | I);
    check("R11 set-time wins, alarm view shown", disp_digits, 16'h0059);
    check("R8 match after commit", {15'd0, alarm_match}, 16'd1);
    press(A);
    press(I);
    check("R11 buffer was not incremented", disp_digits, 16'h0159);

    // R12 clear
    press(F);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R12 clear display", disp_digits, 16'h0000);
    check("R12 clear match", {15'd0, alarm_match}, 16'd1);
    press(I);
    check("R12 hours field after clear", disp_digits, 16'h0100);

    // R8 speaker toggles during a match
    begin
      int ones;
      speaker_ones(ones);
      check("R8 speaker tone during match", 16'(ones), 16'd4);
      press(A);
      check("R5 commit 01:00 as alarm", disp_digits, 16'h0000);
      speaker_ones(ones);
      check("R8 speaker silent without match", 16'(ones), 16'd0);
    end

    // R9 seconds indicator
    begin
      int ones = 0, changes = 0;
      logic prev;
      @(negedge clk); prev = sec_led;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        if (sec_led) ones++;
        if (sec_led != prev) changes++;
        prev = sec_led;
      end
      check("R9 sec_led duty", 16'(ones), 16'd8);
      check("R9 sec_led period", 16'(changes), 16'd4);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule